// File: doc/BRIEF.md
# Branch Aliasing Detection Table

This block measures aliasing in a direct-mapped, tag-less branch predictor organisation. It mirrors the predictor under study: it has the same number of entries and uses the same index function. Each entry holds the full identity of the most recent (address, global history) pair that indexed it, not a prediction counter. Every dynamic conditional branch presented to the block looks up its entry, compares the stored identity with its own, reports the outcome and then overwrites the entry with its own pair. The table therefore behaves like a cache whose lines each hold one datum, and an aliasing event is a miss in that cache.

Two index schemes can be selected for each access. In the folding scheme, the history is XORed into the low address bits. In the joining scheme, the low address bits and the history bits are placed side by side. An entry that has not been touched since reset gives a cold result, which is kept apart from aliasing. Two saturating counters record how many branches were seen and how many of them aliased. Software divides the second count by the first to get the aliasing ratio.

Top module: `branch_alias_table`

## Requirements
- R1: With `idx_mode` = 0 (folding), the index is `addr[IDX_W-1:0]` XOR the history shifted into the top end of that slice: `addr[IDX_W-1:0] ^ {hist, (IDX_W-HIST_W) zeros}` when HIST_W < IDX_W. With the defaults (IDX_W=6, HIST_W=4), `hist` is XORed onto `addr[5:2]`.
- R2: With `idx_mode` = 1 (joining), the index is `{addr[IDX_W-HIST_W-1:0], hist}`, with the history in the low bits. With the defaults, this is `{addr[1:0], hist}`.
- R3: An access sampled with `acc_valid` high at clock edge k produces `res_valid` high, and the index it used on `res_index`, after edge k+1. Accesses may arrive on back-to-back cycles.
- R4: The first access to an entry since reset gives `res_cold` = 1 and `res_alias` = 0.
- R5: An access whose full (address, history) pair equals the pair stored in its entry gives `res_alias` = 0 and `res_cold` = 0.
- R6: An access whose pair differs from the stored pair gives `res_alias` = 1. This includes a difference only in address bits above the index, and an entry last written under the other index mode.
- R7: Every access overwrites its entry with its own pair. The sequence A, B, A on one entry therefore aliases on both B and the second A. An access in the cycle after a write to the same entry sees that write.
- R8: `branch_count` increases by one for every access. `alias_count` increases by one for every access with `res_alias` = 1. Cold accesses and matching accesses leave `alias_count` unchanged.
- R9: Both counters saturate at all ones and stay there.
- R10: Synchronous reset clears both counters, the result outputs and every entry's valid bit.
- R11: `res_alias` and `res_cold` are never high together. They are one-cycle pulses that are high only while `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A conditional branch access is presented |
| acc_addr | input | ADDR_W | Branch address |
| acc_hist | input | HIST_W | Global history bits |
| idx_mode | input | 1 | 0 = folding (XOR) index, 1 = joining (concatenation) index |
| res_valid | output | 1 | Result of an access is present |
| res_alias | output | 1 | The access aliased |
| res_cold | output | 1 | The access found its entry untouched since reset |
| res_index | output | IDX_W | Entry index used by the access |
| branch_count | output | CNT_W | Saturating count of accesses |
| alias_count | output | CNT_W | Saturating count of aliasing events |

## Verification
The assertions run on every cycle. They check that the two flags are exclusive and present only with a result, and that a result appears two edges after each access. They also check that a cold result never moves the alias counter, and that each counter steps by exactly one, holds when idle and sticks at its maximum. Only the bench scenarios can show that the right entry is chosen in each index mode and that identities are compared over the full address. They also show that entries are overwritten so that an A, B, A pattern aliases twice, that a write is seen by the very next access, and that reset really forgets every entry.

// File: rtl/bat_pkg.sv
package bat_pkg;
  typedef enum logic {
    IDX_FOLD = 1'b0,
    IDX_JOIN = 1'b1
  } idx_mode_e;
endpackage

// File: rtl/bat_index.sv
module bat_index
  import bat_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HIST_W = 4,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HIST_W-1:0] hist,
  input  idx_mode_e         mode,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] fold_idx;
  logic [IDX_W-1:0] join_idx;

  generate
    if (HIST_W >= IDX_W) begin : g_long_hist
      assign fold_idx = addr[IDX_W-1:0] ^ hist[IDX_W-1:0];
      assign join_idx = hist[IDX_W-1:0];
    end else begin : g_short_hist
      localparam int PAD_W = IDX_W - HIST_W;
      assign fold_idx = addr[IDX_W-1:0] ^ {hist, {PAD_W{1'b0}}};
      assign join_idx = {addr[PAD_W-1:0], hist};
    end
  endgenerate

  assign idx = (mode == IDX_JOIN) ? join_idx : fold_idx;
endmodule

// File: rtl/bat_store.sv
module bat_store #(
  parameter int IDX_W = 6,
  parameter int KEY_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [KEY_W-1:0] key_in,
  output logic [KEY_W-1:0] rd_key,
  output logic             rd_vld
);
  localparam int DEPTH = 1 << IDX_W;

  logic [KEY_W-1:0] key_mem [DEPTH];
  logic [DEPTH-1:0] vld_bits;

  // read-first RAM: the old identity comes out while the new one goes in
  always_ff @(posedge clk) begin
    if (wr_en) begin
      rd_key       <= key_mem[idx];
      key_mem[idx] <= key_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_bits <= '0;
      rd_vld   <= 1'b0;
    end else if (wr_en) begin
      rd_vld        <= vld_bits[idx];
      vld_bits[idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/bat_sat_counter.sv
module bat_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R8: one step per increment request below the ceiling
  a_r8_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (inc && count != TOP) |=> count == W'($past(count) + 1'b1));

  // R8: no request, no change
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));

  // R9: the ceiling is sticky
  a_r9_sticky_top: assert property (@(posedge clk) disable iff (rst)
    count == TOP |=> count == TOP);
endmodule

// File: rtl/branch_alias_table.sv
module branch_alias_table
  import bat_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HIST_W = 4,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [HIST_W-1:0] acc_hist,
  input  logic              idx_mode,
  output logic              res_valid,
  output logic              res_alias,
  output logic              res_cold,
  output logic [IDX_W-1:0]  res_index,
  output logic [CNT_W-1:0]  branch_count,
  output logic [CNT_W-1:0]  alias_count
);
  localparam int KEY_W = ADDR_W + HIST_W;

  logic [IDX_W-1:0] cur_idx;
  logic [KEY_W-1:0] cur_key;
  logic [KEY_W-1:0] old_key;
  logic             old_vld;

  logic             s1_vld;
  logic [KEY_W-1:0] s1_key;
  logic [IDX_W-1:0] s1_idx;

  logic             hit_cold;
  logic             hit_alias;

  assign cur_key = {acc_addr, acc_hist};

  bat_index #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) u_index (
    .addr (acc_addr),
    .hist (acc_hist),
    .mode (idx_mode_e'(idx_mode)),
    .idx  (cur_idx)
  );

  bat_store #(.IDX_W(IDX_W), .KEY_W(KEY_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (acc_valid),
    .idx    (cur_idx),
    .key_in (cur_key),
    .rd_key (old_key),
    .rd_vld (old_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_key <= '0;
      s1_idx <= '0;
    end else begin
      s1_vld <= acc_valid;
      s1_key <= cur_key;
      s1_idx <= cur_idx;
    end
  end

  assign hit_cold  = s1_vld && !old_vld;
  assign hit_alias = s1_vld && old_vld && (old_key != s1_key);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_alias <= 1'b0;
      res_cold  <= 1'b0;
      res_index <= '0;
    end else begin
      res_valid <= s1_vld;
      res_alias <= hit_alias;
      res_cold  <= hit_cold;
      res_index <= s1_idx;
    end
  end

  bat_sat_counter #(.W(CNT_W)) u_branch_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (s1_vld),
    .count (branch_count)
  );

  bat_sat_counter #(.W(CNT_W)) u_alias_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (hit_alias),
    .count (alias_count)
  );

  // R11: a result is cold or aliased, never both
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(res_alias && res_cold));

  // R11: flags only accompany a result
  a_r11_flags_need_result: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_alias && !res_cold));

  // R3: every access yields a result two edges later
  a_r3_result_latency: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> ##2 res_valid);

  // R8: a cold result never moves the alias counter
  a_r8_cold_not_counted: assert property (@(posedge clk) disable iff (rst)
    res_cold |-> alias_count == $past(alias_count));
endmodule

// File: tb/branch_alias_table_test.sv
`timescale 1ns/1ps
module branch_alias_table_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [3:0]  acc_hist = '0;
  logic        idx_mode = 1'b0;

  logic        res_valid, res_alias, res_cold;
  logic [5:0]  res_index;
  logic [31:0] branch_count, alias_count;

  logic        s_valid, s_alias, s_cold;
  logic [5:0]  s_index;
  logic [2:0]  s_branch, s_alias_cnt;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  branch_alias_table uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_hist(acc_hist), .idx_mode(idx_mode), .res_valid(res_valid),
    .res_alias(res_alias), .res_cold(res_cold), .res_index(res_index),
    .branch_count(branch_count), .alias_count(alias_count)
  );

  // narrow-counter copy for the saturation checks (R9)
  branch_alias_table #(.CNT_W(3)) uut_sat (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_hist(acc_hist), .idx_mode(idx_mode), .res_valid(s_valid),
    .res_alias(s_alias), .res_cold(s_cold), .res_index(s_index),
    .branch_count(s_branch), .alias_count(s_alias_cnt)
  );

  // {mode, addr, hist, expected index, expected alias, expected cold}
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 16'h0012, 4'h3, 6'h1E, 1'b0, 1'b1},  // R1 R4 cold
    {1'b0, 16'h0012, 4'h3, 6'h1E, 1'b0, 1'b0},  // R5 same pair
    {1'b0, 16'h0016, 4'h2, 6'h1E, 1'b1, 1'b0},  // R6 other pair, same slot
    {1'b0, 16'h0012, 4'h3, 6'h1E, 1'b1, 1'b0},  // R7 overwritten
    {1'b0, 16'h1012, 4'h3, 6'h1E, 1'b1, 1'b0},  // R6 upper address only
    {1'b1, 16'h0003, 4'h5, 6'h35, 1'b0, 1'b1},  // R2 cold
    {1'b1, 16'h00F3, 4'h5, 6'h35, 1'b1, 1'b0},  // R2 R6
    {1'b1, 16'h00F3, 4'h5, 6'h35, 1'b0, 1'b0},  // R5
    {1'b1, 16'h0012, 4'hE, 6'h2E, 1'b0, 1'b1},  // R2
    {1'b0, 16'h0001, 4'hB, 6'h2D, 1'b0, 1'b1},  // R1
    {1'b0, 16'h003F, 4'hF, 6'h03, 1'b0, 1'b1},  // R1
    {1'b1, 16'h1012, 4'h3, 6'h23, 1'b0, 1'b1},  // R2
    {1'b0, 16'h0023, 4'h0, 6'h23, 1'b1, 1'b0},  // R6 cross-mode
    {1'b1, 16'h0012, 4'hE, 6'h2E, 1'b0, 1'b0}   // R5 survives
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [15:0] a, input logic [3:0] h);
    idx_mode  = m;
    acc_addr  = a;
    acc_hist  = h;
    acc_valid = 1'b1;
  endtask

  // one access, then sample at the falling edge after its result edge
  task automatic single(input logic m, input logic [15:0] a, input logic [3:0] h);
    @(negedge clk);
    drive(m, a, h);
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset branch_count", branch_count, 0);
    check("R10 reset alias_count", alias_count, 0);
    check("R10 reset res_valid", {31'b0, res_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      single(VEC[i][28], VEC[i][27:12], VEC[i][11:8]);
      check("R3 res_valid", {31'b0, res_valid}, 1);
      check("R1/R2 res_index", {26'b0, res_index}, {26'b0, VEC[i][7:2]});
      check("R6/R7 res_alias", {31'b0, res_alias}, {31'b0, VEC[i][1]});
      check("R4 res_cold", {31'b0, res_cold}, {31'b0, VEC[i][0]});
    end
    check("R8 branch_count", branch_count, 14);
    check("R8 alias_count", alias_count, 5);

    // R7 back-to-back writes to entry 0
    @(negedge clk);
    drive(1'b0, 16'h0000, 4'h0);
    @(negedge clk);
    drive(1'b0, 16'h0100, 4'h0);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R4 first of pair cold", {30'b0, res_cold, res_alias}, 2);
    @(negedge clk);
    check("R7 next-cycle alias", {30'b0, res_cold, res_alias}, 1);
    @(negedge clk);
    check("R11 pulse ends", {29'b0, res_valid, res_cold, res_alias}, 0);
    check("R8 branch_count after pair", branch_count, 16);
    check("R8 alias_count after pair", alias_count, 6);
    check("R9 narrow branch_count saturated", {29'b0, s_branch}, 7);
    repeat (3) @(negedge clk);
    check("R8 idle keeps count", branch_count, 16);

    // R10 reset forgets entries
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 counts cleared", branch_count | alias_count, 0);
    single(1'b0, 16'h0012, 4'h3);
    check("R10 entry invalid again", {30'b0, res_cold, res_alias}, 2);

    // R9 saturation: one cold then nine aliases on entry 0
    for (int k = 0; k < 10; k++)
      single(1'b0, (k % 2 == 0) ? 16'h0040 : 16'h0080, 4'h0);
    check("R9 narrow branch_count", {29'b0, s_branch}, 7);
    check("R9 narrow alias_count", {29'b0, s_alias_cnt}, 7);
    check("R8 wide branch_count", branch_count, 11);
    check("R8 wide alias_count", alias_count, 9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule